// File: doc/BRIEF.md
# Protected Power Mode Controller

This block keeps track of the power mode of a small microcontroller-style system and decides when that mode may change. Software drives it through a byte-wide register port with four registers: a write-once permission register, a mode control register, a deep-stop control register and a read-only mode status register. Run-mode changes come from writes to the control register. Stop entry comes from a sleep request qualified by a deep-sleep input. Each change is allowed only when the permission register has enabled the target mode family.

Stop entry is a fixed sequence of several cycles. An interrupt during that sequence cancels the entry and raises a sticky aborted flag. An interrupt during a stop or wait mode wakes the system. Whether it wakes to normal run or stays in low-power run depends on a control bit and on the mode the stop was entered from. The current mode is reported as a registered one-hot status byte. While a debug input is active, that byte never shows normal stop or low-power stop.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the registers read as follows: permission (address 0) 0x00, control (address 1) 0x00, deep-stop control (address 2) 0x03, status (address 3) 0x01.
- R2: The permission register keeps only bits 1 (deep stop allowed), 3 (low-leakage stop allowed) and 5 (low-power modes allowed); all other bits read 0. Only the first write after reset takes effect, and every later write leaves the value unchanged.
- R3: Control bits [2:0] select the stop target: 000 normal stop (always allowed), 010 low-power stop (needs permission bit 5), 011 low-leakage stop (needs bit 3), 100 deep stop (needs bit 1). A reserved or disallowed code leaves the field unchanged.
- R4: Writing control bits [6:5] = 10 enters low-power run at the edge that takes the write, but only with permission bit 5 set and the system in normal run. Writing 00 while in low-power run returns to normal run. Any other write leaves the run mode as it is. Bits [6:5] read 10 while in the low-power family and 00 otherwise.
- R5: Sleep request together with deep sleep, taken in normal run or low-power run, starts entry. The status shows the target mode at the 4th edge after the request edge. Select code 000 taken from low-power run targets low-power stop.
- R6: An interrupt during the entry sequence returns the system to the mode it came from and sets control bit 3. Bit 3 is cleared when the next entry starts.
- R7: An interrupt in normal stop, low-leakage stop or deep stop returns the system to normal run at the next edge.
- R8: With control bit 7 = 1, an interrupt in low-power run, low-power wait or low-power stop returns to normal run. With bit 7 = 0, low-power wait and low-power stop return to low-power run. A low-power stop entered from normal run always wakes to normal run.
- R9: Sleep request without deep sleep, taken in low-power run, enters low-power wait at the next edge. In normal run it has no effect.
- R10: The status byte is one-hot: bit 0 normal run, bit 1 normal stop, bit 2 low-power run, bit 3 low-power wait, bit 4 low-power stop, bit 5 low-leakage stop, bit 6 deep stop. Bit 7 is always 0. During entry the status shows the mode the entry came from.
- R11: While the debug input is high, the status does not change to bit 1 or bit 4. It keeps its previous value instead.
- R12: Deep-stop control bits [2:0] take codes 000 to 011. Higher codes leave the field unchanged. Bit 5 is a plain stored option, and the other bits read 0.
- R13: Control bit 7 can be written only while in normal run. Writes in any other mode leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register address: 0 permission, 1 control, 2 deep-stop control, 3 status |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| sleep_req | input | 1 | Sleep request, one cycle |
| deep_sleep | input | 1 | Qualifies a sleep request as a stop request |
| irq | input | 1 | Interrupt / wakeup event |
| dbg_en | input | 1 | Debug active |
| mode_status | output | 8 | Registered one-hot current mode |

## Verification
The bench builds the block with its default parameters: a 4-cycle entry sequence and 4 deep-stop submodes. This keeps every abort position inside the entry window within a few cycles, and lets all legal and reserved submode codes be written. Two resets separate the permission settings that are tried, because permission can be set only once per reset. One setting enables every mode family and the other only low-leakage stop, so both the granted and the refused paths of each request are taken.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    PM_RUN    = 3'd0,
    PM_STOP   = 3'd1,
    PM_LPRUN  = 3'd2,
    PM_LPWAIT = 3'd3,
    PM_LPSTOP = 3'd4,
    PM_LLSTOP = 3'd5,
    PM_DEEP   = 3'd6,
    PM_ENTER  = 3'd7
  } pm_state_e;

  localparam int NUM_MODES = 7;

  localparam logic [2:0] SEL_STOP   = 3'b000;
  localparam logic [2:0] SEL_LPSTOP = 3'b010;
  localparam logic [2:0] SEL_LLS    = 3'b011;
  localparam logic [2:0] SEL_DEEP   = 3'b100;

  localparam int PERM_DEEP = 1;
  localparam int PERM_LLS  = 3;
  localparam int PERM_LP   = 5;

  localparam int ADDR_PERM = 0;
  localparam int ADDR_CTRL = 1;
  localparam int ADDR_DEEP = 2;
  localparam int ADDR_STAT = 3;

endpackage

// File: rtl/pmc_regs.sv
module pmc_regs
  import pmc_pkg::*;
#(
  parameter int DW      = 8,
  parameter int AW      = 2,
  parameter int NUM_SUB = 4,
  parameter int SUB_W   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          in_run,
  input  logic          run_lp,
  input  logic          abort,
  input  logic [DW-1:0] status,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] perm_q,
  output logic          perm_locked,
  output logic [2:0]    stop_sel,
  output logic          wake_run,
  output logic          req_lp,
  output logic          req_norm
);

  localparam logic [DW-1:0] PERM_MASK =
    DW'((1 << PERM_DEEP) | (1 << PERM_LLS) | (1 << PERM_LP));
  localparam logic [SUB_W-1:0] SUB_RST = SUB_W'(NUM_SUB - 1);

  logic             wr_perm, wr_ctrl, wr_deep;
  logic             sel_ok;
  logic [SUB_W-1:0] sub_q;
  logic             bod_off_q;

  assign wr_perm = wr && (addr == AW'(ADDR_PERM));
  assign wr_ctrl = wr && (addr == AW'(ADDR_CTRL));
  assign wr_deep = wr && (addr == AW'(ADDR_DEEP));

  always_comb begin
    case (wdata[2:0])
      SEL_STOP:   sel_ok = 1'b1;
      SEL_LPSTOP: sel_ok = perm_q[PERM_LP];
      SEL_LLS:    sel_ok = perm_q[PERM_LLS];
      SEL_DEEP:   sel_ok = perm_q[PERM_DEEP];
      default:    sel_ok = 1'b0;
    endcase
  end

  assign req_lp   = wr_ctrl && (wdata[6:5] == 2'b10) && perm_q[PERM_LP];
  assign req_norm = wr_ctrl && (wdata[6:5] == 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      perm_q      <= '0;
      perm_locked <= 1'b0;
    end else if (wr_perm && !perm_locked) begin
      perm_q      <= wdata & PERM_MASK;
      perm_locked <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_sel <= SEL_STOP;
      wake_run <= 1'b0;
    end else if (wr_ctrl) begin
      if (sel_ok) stop_sel <= wdata[2:0];
      if (in_run) wake_run <= wdata[7];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_q     <= SUB_RST;
      bod_off_q <= 1'b0;
    end else if (wr_deep) begin
      if (int'(wdata[SUB_W-1:0]) < NUM_SUB) sub_q <= wdata[SUB_W-1:0];
      bod_off_q <= wdata[5];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(ADDR_PERM): rdata = perm_q;
      AW'(ADDR_CTRL): begin
        rdata[2:0] = stop_sel;
        rdata[3]   = abort;
        rdata[6:5] = {run_lp, 1'b0};
        rdata[7]   = wake_run;
      end
      AW'(ADDR_DEEP): begin
        rdata[SUB_W-1:0] = sub_q;
        rdata[5]         = bod_off_q;
      end
      default: rdata = status;
    endcase
  end

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
#(
  parameter int DW        = 8,
  parameter int ENTRY_CYC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep_req,
  input  logic          deep_sleep,
  input  logic          irq,
  input  logic          dbg_en,
  input  logic [2:0]    stop_sel,
  input  logic          wake_run,
  input  logic          req_lp,
  input  logic          req_norm,
  output logic [DW-1:0] status_q,
  output logic          run_lp_q,
  output logic          abort_q,
  output logic          entering,
  output logic          in_run
);

  localparam int CNT_W = $clog2(ENTRY_CYC + 1);

  pm_state_e        state_q, state_n, origin_q, origin_n, target_q, target_n, disp;
  logic             from_run_q, from_run_n, abort_n, lp_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [DW-1:0]    onehot, status_n;

  function automatic pm_state_e map_stop(input logic [2:0] sel, input logic from_run);
    case (sel)
      SEL_LPSTOP: map_stop = PM_LPSTOP;
      SEL_LLS:    map_stop = PM_LLSTOP;
      SEL_DEEP:   map_stop = PM_DEEP;
      default:    map_stop = from_run ? PM_STOP : PM_LPSTOP;
    endcase
  endfunction

  always_comb begin
    state_n    = state_q;
    origin_n   = origin_q;
    target_n   = target_q;
    from_run_n = from_run_q;
    cnt_n      = cnt_q;
    abort_n    = abort_q;
    lp_n       = run_lp_q;
    case (state_q)
      PM_RUN: begin
        if (sleep_req && deep_sleep) begin
          state_n    = PM_ENTER;
          origin_n   = PM_RUN;
          target_n   = map_stop(stop_sel, 1'b1);
          from_run_n = 1'b1;
          cnt_n      = '0;
          abort_n    = 1'b0;
        end else if (req_lp) begin
          state_n = PM_LPRUN;
          lp_n    = 1'b1;
        end
      end
      PM_LPRUN: begin
        if (irq && wake_run) begin
          state_n = PM_RUN;
          lp_n    = 1'b0;
        end else if (sleep_req && deep_sleep) begin
          state_n    = PM_ENTER;
          origin_n   = PM_LPRUN;
          target_n   = map_stop(stop_sel, 1'b0);
          from_run_n = 1'b0;
          cnt_n      = '0;
          abort_n    = 1'b0;
        end else if (sleep_req) begin
          state_n = PM_LPWAIT;
        end else if (req_norm) begin
          state_n = PM_RUN;
          lp_n    = 1'b0;
        end
      end
      PM_LPWAIT: begin
        if (irq) begin
          state_n = wake_run ? PM_RUN : PM_LPRUN;
          lp_n    = !wake_run;
        end
      end
      PM_LPSTOP: begin
        if (irq) begin
          state_n = (from_run_q || wake_run) ? PM_RUN : PM_LPRUN;
          lp_n    = !(from_run_q || wake_run);
        end
      end
      PM_ENTER: begin
        if (irq) begin
          state_n = origin_q;
          abort_n = 1'b1;
        end else if (cnt_q == CNT_W'(ENTRY_CYC - 1)) begin
          state_n = target_q;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      default: begin
        if (irq) begin
          state_n = PM_RUN;
          lp_n    = 1'b0;
        end
      end
    endcase
  end

  assign disp = (state_n == PM_ENTER) ? origin_n : state_n;

  for (genvar g = 0; g < DW; g++) begin : g_onehot
    if (g < NUM_MODES) begin : g_mode
      assign onehot[g] = (disp == pm_state_e'(g));
    end else begin : g_unused
      assign onehot[g] = 1'b0;
    end
  end

  assign status_n = (dbg_en && (disp == PM_STOP || disp == PM_LPSTOP)) ? status_q : onehot;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= PM_RUN;
      origin_q   <= PM_RUN;
      target_q   <= PM_STOP;
      from_run_q <= 1'b1;
      cnt_q      <= '0;
      abort_q    <= 1'b0;
      run_lp_q   <= 1'b0;
      status_q   <= DW'(1);
    end else begin
      state_q    <= state_n;
      origin_q   <= origin_n;
      target_q   <= target_n;
      from_run_q <= from_run_n;
      cnt_q      <= cnt_n;
      abort_q    <= abort_n;
      run_lp_q   <= lp_n;
      status_q   <= status_n;
    end
  end

  assign entering = (state_q == PM_ENTER);
  assign in_run   = (state_q == PM_RUN);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int DW        = 8,
  parameter int AW        = 2,
  parameter int ENTRY_CYC = 4,
  parameter int NUM_SUB   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          sleep_req,
  input  logic          deep_sleep,
  input  logic          irq,
  input  logic          dbg_en,
  output logic [DW-1:0] mode_status
);

  localparam int SUB_W = 3;

  logic [DW-1:0] prot_bits;
  logic          prot_locked;
  logic [2:0]    stop_sel;
  logic          wake_run, req_lp, req_norm;
  logic          run_lp, abort_flag, entering, in_run;

  pmc_regs #(.DW(DW), .AW(AW), .NUM_SUB(NUM_SUB), .SUB_W(SUB_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .in_run(in_run), .run_lp(run_lp), .abort(abort_flag), .status(mode_status),
    .rdata(reg_rdata), .perm_q(prot_bits), .perm_locked(prot_locked),
    .stop_sel(stop_sel), .wake_run(wake_run), .req_lp(req_lp), .req_norm(req_norm)
  );

  pmc_fsm #(.DW(DW), .ENTRY_CYC(ENTRY_CYC)) u_fsm (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .deep_sleep(deep_sleep),
    .irq(irq), .dbg_en(dbg_en), .stop_sel(stop_sel), .wake_run(wake_run),
    .req_lp(req_lp), .req_norm(req_norm), .status_q(mode_status),
    .run_lp_q(run_lp), .abort_q(abort_flag), .entering(entering), .in_run(in_run)
  );

endmodule

// File: rtl/pmc_chk.sv
module pmc_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] mode_status,
  input logic          irq,
  input logic          dbg_en,
  input logic          entering,
  input logic          abort_flag,
  input logic [DW-1:0] prot_bits,
  input logic          prot_locked
);

  // R10
  status_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(mode_status) == 1) && !mode_status[DW-1]);

  // R11
  dbg_no_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_en && !mode_status[1]) |=> !mode_status[1]);

  // R11
  dbg_no_lpstop_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_en && !mode_status[4]) |=> !mode_status[4]);

  // R6
  entry_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (entering && irq) |=> (abort_flag && !entering));

  // R7
  deep_wake_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_status[5] || mode_status[6]) && irq) |=> mode_status[0]);

  // R2
  perm_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    prot_locked |=> $stable(prot_bits));

endmodule

bind pwr_mode_ctrl pmc_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .mode_status(mode_status), .irq(irq), .dbg_en(dbg_en),
  .entering(entering), .abort_flag(abort_flag), .prot_bits(prot_bits),
  .prot_locked(prot_locked)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sleep_req = 1'b0, deep_sleep = 1'b0, irq = 1'b0, dbg_en = 1'b0;
  logic [7:0] mode_status;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwr_mode_ctrl u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sleep_req(sleep_req), .deep_sleep(deep_sleep), .irq(irq),
    .dbg_en(dbg_en), .mode_status(mode_status)
  );

  // Reference model. Modes: 0 run,1 stop,2 lp run,3 lp wait,4 lp stop,5 ll stop,6 deep, 7 entering
  int m_st, m_org, m_tgt, m_cnt;
  bit m_fr, m_ab, m_lp, m_lock, m_wake, m_bod;
  logic [7:0] m_prot, m_status;
  logic [2:0] m_sel, m_sub;

  function automatic bit sel_ok(logic [2:0] c, logic [7:0] p);
    case (c)
      3'b000: return 1'b1;
      3'b010: return p[5];
      3'b011: return p[3];
      3'b100: return p[1];
      default: return 1'b0;
    endcase
  endfunction

  function automatic int tmap(logic [2:0] c, bit fr);
    case (c)
      3'b010: return 4;
      3'b011: return 5;
      3'b100: return 6;
      default: return fr ? 1 : 4;
    endcase
  endfunction

  function automatic logic [7:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return m_prot;
      2'd1: return {m_wake, m_lp, 1'b0, 1'b0, m_ab, m_sel};
      2'd2: return {2'b00, m_bod, 2'b00, m_sub};
      default: return m_status;
    endcase
  endfunction

  always @(posedge clk) begin
    int st, disp;
    bit wrc, was_run;
    if (rst) begin
      m_st = 0; m_org = 0; m_tgt = 1; m_cnt = 0; m_fr = 1; m_ab = 0; m_lp = 0;
      m_lock = 0; m_wake = 0; m_bod = 0; m_prot = 0; m_status = 8'h01; m_sel = 0; m_sub = 3;
    end else begin
      wrc = reg_wr && reg_addr == 2'd1;
      was_run = (m_st == 0);
      st = m_st;
      case (m_st)
        0: if (sleep_req && deep_sleep) begin
             st = 7; m_org = 0; m_cnt = 0; m_ab = 0; m_fr = 1; m_tgt = tmap(m_sel, 1);
           end else if (wrc && reg_wdata[6:5] == 2'b10 && m_prot[5]) begin
             st = 2; m_lp = 1;
           end
        2: if (irq && m_wake) begin st = 0; m_lp = 0; end
           else if (sleep_req && deep_sleep) begin
             st = 7; m_org = 2; m_cnt = 0; m_ab = 0; m_fr = 0; m_tgt = tmap(m_sel, 0);
           end else if (sleep_req) st = 3;
           else if (wrc && reg_wdata[6:5] == 2'b00) begin st = 0; m_lp = 0; end
        3: if (irq) begin
             if (m_wake) begin st = 0; m_lp = 0; end else st = 2;
           end
        4: if (irq) begin
             if (m_fr || m_wake) begin st = 0; m_lp = 0; end else st = 2;
           end
        7: if (irq) begin st = m_org; m_ab = 1; end
           else if (m_cnt == 3) st = m_tgt;
           else m_cnt++;
        default: if (irq) begin st = 0; m_lp = 0; end
      endcase
      m_st = st;
      disp = (st == 7) ? m_org : st;
      if (!(dbg_en && (disp == 1 || disp == 4))) m_status = 8'(1 << disp);
      if (reg_wr) begin
        case (reg_addr)
          2'd0: if (!m_lock) begin m_prot = reg_wdata & 8'h2A; m_lock = 1; end
          2'd1: begin
            if (sel_ok(reg_wdata[2:0], m_prot)) m_sel = reg_wdata[2:0];
            if (was_run) m_wake = reg_wdata[7];
          end
          2'd2: begin
            if (reg_wdata[2:0] < 3'd4) m_sub = reg_wdata[2:0];
            m_bod = reg_wdata[5];
          end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model (R10 status, plus the addressed read)
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R10 status vs model", mode_status, m_status);
      chk("R1 read vs model", reg_rdata, m_read(reg_addr));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    cyc(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(string tag, logic [1:0] a, logic [7:0] exp);
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
    cyc(1);
  endtask

  task automatic slp(bit deep);
    sleep_req = 1'b1; deep_sleep = deep;
    cyc(1);
    sleep_req = 1'b0; deep_sleep = 1'b0;
  endtask

  task automatic wake();
    irq = 1'b1;
    cyc(1);
    irq = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(3);
    rst = 1'b0;
    cyc(1);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset values
    rd("R1 perm", 2'd0, 8'h00);
    rd("R1 ctrl", 2'd1, 8'h00);
    rd("R1 deep", 2'd2, 8'h03);
    rd("R1 status", 2'd3, 8'h01);

    // R4 / R3 refused without permission
    wr(2'd1, 8'h42);
    rd("R4 lp run refused", 2'd3, 8'h01);
    rd("R3 lp stop code refused", 2'd1, 8'h00);

    // R5 normal stop entry, R7 wake
    slp(1'b1);
    cyc(3);
    chk("R5 not yet in stop", mode_status, 8'h01);
    cyc(1);
    chk("R5 normal stop", mode_status, 8'h02);
    wake();
    chk("R7 stop wakes to run", mode_status, 8'h01);

    // R2 write-once permission
    wr(2'd0, 8'hFF);
    rd("R2 masked perm", 2'd0, 8'h2A);
    wr(2'd0, 8'h00);
    rd("R2 second write ignored", 2'd0, 8'h2A);

    // R3 reserved code, then legal low-leakage code
    wr(2'd1, 8'h05);
    rd("R3 reserved code ignored", 2'd1, 8'h00);
    wr(2'd1, 8'h03);
    rd("R3 ll stop accepted", 2'd1, 8'h03);

    // R12 deep-stop control
    wr(2'd2, 8'hFD);
    rd("R12 reserved submode kept", 2'd2, 8'h23);
    wr(2'd2, 8'h02);
    rd("R12 submode 2", 2'd2, 8'h02);

    // R6 abort, then clean entry clears flag
    slp(1'b1);
    cyc(1);
    wake();
    chk("R6 aborted back to run", mode_status, 8'h01);
    rd("R6 abort flag set", 2'd1, 8'h0B);
    slp(1'b1);
    rd("R6 abort flag cleared at start", 2'd1, 8'h03);
    cyc(3);
    chk("R5 ll stop reached", mode_status, 8'h20);
    wake();
    chk("R7 ll stop wakes to run", mode_status, 8'h01);

    // R8 low-power stop from run with wake bit 1
    wr(2'd1, 8'h82);
    slp(1'b1);
    cyc(4);
    chk("R5 lp stop from run", mode_status, 8'h10);
    wake();
    chk("R8 lp stop from run wakes to run", mode_status, 8'h01);

    // R8 wake bit 0 in the low-power family
    wr(2'd1, 8'h02);
    wr(2'd1, 8'h42);
    chk("R4 lp run entered", mode_status, 8'h04);
    rd("R4 run field reads 10", 2'd1, 8'h42);
    wr(2'd1, 8'hC2);
    rd("R13 wake bit ignored outside run", 2'd1, 8'h42);
    slp(1'b0);
    chk("R9 lp wait", mode_status, 8'h08);
    wake();
    chk("R8 lp wait wakes to lp run", mode_status, 8'h04);
    wr(2'd1, 8'h40);
    slp(1'b1);
    cyc(4);
    chk("R5 code 000 from lp run gives lp stop", mode_status, 8'h10);
    wake();
    chk("R8 lp stop from lp run stays lp", mode_status, 8'h04);
    wr(2'd1, 8'h00);
    chk("R4 back to run", mode_status, 8'h01);

    // R8 wake bit 1 from lp run
    wr(2'd1, 8'h80);
    wr(2'd1, 8'hC0);
    chk("R4 lp run again", mode_status, 8'h04);
    wake();
    chk("R8 lp run irq to run", mode_status, 8'h01);
    rd("R4 run field back to 00", 2'd1, 8'h80);

    // R9 sleep without deep in run: no effect
    slp(1'b0);
    chk("R9 no wait from run", mode_status, 8'h01);

    // R11 debug hides normal stop
    dbg_en = 1'b1;
    wr(2'd1, 8'h00);
    slp(1'b1);
    cyc(5);
    chk("R11 status held in debug", mode_status, 8'h01);
    wake();
    dbg_en = 1'b0;
    cyc(1);

    // Deep stop
    wr(2'd1, 8'h04);
    slp(1'b1);
    cyc(4);
    chk("R10 deep stop bit 6", mode_status, 8'h40);
    wake();
    chk("R7 deep stop wakes to run", mode_status, 8'h01);

    // Second permission setting: only low-leakage stop
    do_reset();
    wr(2'd0, 8'h08);
    wr(2'd1, 8'h04);
    rd("R3 deep code refused", 2'd1, 8'h00);
    wr(2'd1, 8'h42);
    rd("R4 lp run refused without bit 5", 2'd3, 8'h01);
    wr(2'd1, 8'h03);
    rd("R3 ll code allowed", 2'd1, 8'h03);

    cyc(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule